// File: doc/BRIEF.md
# Temperature Alert Qualifier

This block watches a stream of signed temperature samples and drives a single alert pin. Each accepted sample is compared with a high limit and a low limit. A consecutive-fault counter filters the result, so that a single stray sample does not move the pin. The required run length is set by a two-bit field.

The block has two modes. In comparator mode the alert follows the temperature with hysteresis. It turns on after a run of samples at or above the high limit. It turns off only after a run of samples below the low limit. In interrupt mode an event latches the alert until it is cleared. Three things clear it: a register read, an alert-response acknowledge, or entry into shutdown. After each clear, the threshold being watched swaps between high and low.

A general-call reset clears everything and forces comparator mode. Samples arrive on a valid/ready interface. Ready is low only in a cycle in which general-call reset is asserted, and a sample offered in that cycle is dropped. In every other cycle a sample is accepted on the clock edge where valid is high. The producer may hold valid for several cycles, and every such cycle counts as one sample.

Top module: `tmp_alert_top`

## Requirements
- R1: In comparator mode, while the alert is inactive, it becomes active on the accepted sample that completes a run of N consecutive samples with temp >= high limit. N is 1, 2, 4 and 6 for the fault field values 00, 01, 10 and 11.
- R2: In comparator mode, an active alert becomes inactive only on the accepted sample that completes a run of N consecutive samples with temp < low limit. A sample equal to the low limit does not count.
- R3: An accepted sample that fails the condition currently being watched resets the run count to zero.
- R4: In interrupt mode, the alert becomes active after N consecutive samples at or above the high limit. While it is active, samples have no effect.
- R5: In interrupt mode, an active alert is cleared by a read pulse, an acknowledge pulse, or a rising edge of the shutdown flag. In comparator mode these inputs have no effect on the alert.
- R6: In interrupt mode, after each clear the watched condition swaps: first temp < low limit, then temp >= high limit again, and this repeats.
- R7: General-call reset makes the alert inactive, clears the run count and the swap state, and drops smp_ready_o in that cycle. It also forces comparator mode until mode_i has been seen at 0.
- R8: Comparisons use all TW bits as signed two's complement.
- R9: pol_i = 1 makes alert_o active-high; pol_i = 0 makes it active-low. The alert is inactive after reset.
- R10: The alert state changes only after an accepted sample, a clear, a general-call reset, or a change of effective mode. A change of effective mode makes the alert inactive and clears the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample offered |
| smp_ready_o | output | 1 | Sample can be taken (low during general-call reset) |
| smp_temp_i | input | TW | Signed temperature sample |
| lim_hi_i | input | TW | Signed high limit |
| lim_lo_i | input | TW | Signed low limit |
| mode_i | input | 1 | 0 comparator, 1 interrupt |
| fq_sel_i | input | 2 | Consecutive-fault setting |
| pol_i | input | 1 | Alert polarity (1 active-high) |
| sd_i | input | 1 | Shutdown flag |
| rd_i | input | 1 | Register-read pulse |
| ara_i | input | 1 | Alert-response acknowledge pulse |
| gc_i | input | 1 | General-call reset pulse |
| alert_o | output | 1 | Alert pin level |

## Verification
The bench builds the block with the default TW of 12. This puts the full sign range from -2048 to 2047 within reach, along with limits that differ only in their least significant bit. With these values the bench can show that the comparison is signed rather than unsigned, and that a limit one LSB above a sample blocks the alert. The bench covers all four fault-count settings, including the longest run of six samples.

// File: rtl/tmp_alert_pkg.sv
package tmp_alert_pkg;
  typedef enum logic [1:0] {FQ_ONE = 2'd0, FQ_TWO = 2'd1, FQ_FOUR = 2'd2, FQ_SIX = 2'd3} fq_e;
  localparam int CNT_W = 3;

  function automatic logic [CNT_W-1:0] fq_need(input logic [1:0] sel);
    case (fq_e'(sel))
      FQ_ONE:  fq_need = 3'd1;
      FQ_TWO:  fq_need = 3'd2;
      FQ_FOUR: fq_need = 3'd4;
      default: fq_need = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/tmp_alert_cmp.sv
module tmp_alert_cmp #(
  parameter int TW = 12
) (
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] hi_i,
  input  logic [TW-1:0] lo_i,
  output logic          ge_hi_o,
  output logic          lt_lo_o
);
  logic signed [TW-1:0] t_s, h_s, l_s;
  assign t_s = signed'(temp_i);
  assign h_s = signed'(hi_i);
  assign l_s = signed'(lo_i);
  assign ge_hi_o = (t_s >= h_s);
  assign lt_lo_o = (t_s < l_s);
endmodule

// File: rtl/tmp_alert_qual.sv
module tmp_alert_qual
  import tmp_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             hit_i,
  input  logic             flush_i,
  input  logic [1:0]       fq_sel_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  assign cnt_inc = cnt_q + 1'b1;
  assign done_o  = step_i && hit_i && (cnt_inc >= fq_need(fq_sel_i));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (flush_i)                cnt_q <= '0;
    else if (step_i) begin
      if (!hit_i || done_o)          cnt_q <= '0;
      else                           cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/tmp_alert_ctrl.sv
module tmp_alert_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic gc_i,
  input  logic rd_i,
  input  logic ara_i,
  input  logic sd_i,
  input  logic smp_fire_i,
  input  logic done_i,
  output logic act_o,
  output logic watch_low_o,
  output logic step_o,
  output logic flush_o,
  output logic mode_eff_o
);
  logic act_q, arm_low_q, force_q, mode_q, sd_q;
  logic mode_eff, mode_chg, sd_rise, clr_evt, int_hold;

  assign mode_eff = mode_i & ~force_q;
  assign mode_chg = (mode_eff != mode_q);
  assign sd_rise  = sd_i & ~sd_q;
  assign clr_evt  = mode_eff && act_q && (rd_i || ara_i || sd_rise);
  assign int_hold = mode_eff && act_q;

  assign watch_low_o = mode_eff ? arm_low_q : act_q;
  assign step_o      = smp_fire_i && !int_hold && !mode_chg && !gc_i;
  assign flush_o     = gc_i || mode_chg || clr_evt || int_hold;
  assign act_o       = act_q;
  assign mode_eff_o  = mode_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; arm_low_q <= 1'b0; force_q <= 1'b0;
      mode_q <= 1'b0; sd_q <= 1'b0;
    end else begin
      sd_q <= sd_i;
      if (gc_i) begin
        act_q <= 1'b0; arm_low_q <= 1'b0; force_q <= 1'b1; mode_q <= 1'b0;
      end else begin
        if (!mode_i) force_q <= 1'b0;
        mode_q <= mode_eff;
        if (mode_chg) begin
          act_q <= 1'b0; arm_low_q <= 1'b0;
        end else if (clr_evt) begin
          act_q <= 1'b0; arm_low_q <= ~arm_low_q;
        end else if (done_i) begin
          act_q <= mode_eff ? 1'b1 : ~act_q;
        end
      end
    end
  end
endmodule

// File: rtl/tmp_alert_top.sv
module tmp_alert_top
  import tmp_alert_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid_i,
  output logic          smp_ready_o,
  input  logic [TW-1:0] smp_temp_i,
  input  logic [TW-1:0] lim_hi_i,
  input  logic [TW-1:0] lim_lo_i,
  input  logic          mode_i,
  input  logic [1:0]    fq_sel_i,
  input  logic          pol_i,
  input  logic          sd_i,
  input  logic          rd_i,
  input  logic          ara_i,
  input  logic          gc_i,
  output logic          alert_o
);
  logic ge_hi, lt_lo, hit, done, act, watch_low, step, flush, mode_eff, smp_fire;
  logic [CNT_W-1:0] cnt;

  assign smp_ready_o = ~gc_i;
  assign smp_fire    = smp_valid_i & smp_ready_o;
  assign hit         = watch_low ? lt_lo : ge_hi;
  assign alert_o     = pol_i ? act : ~act;

  tmp_alert_cmp #(.TW(TW)) u_cmp (
    .temp_i(smp_temp_i), .hi_i(lim_hi_i), .lo_i(lim_lo_i),
    .ge_hi_o(ge_hi), .lt_lo_o(lt_lo)
  );

  tmp_alert_qual u_qual (
    .clk(clk), .rst_n(rst_n), .step_i(step), .hit_i(hit), .flush_i(flush),
    .fq_sel_i(fq_sel_i), .done_o(done), .cnt_o(cnt)
  );

  tmp_alert_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .gc_i(gc_i), .rd_i(rd_i),
    .ara_i(ara_i), .sd_i(sd_i), .smp_fire_i(smp_fire), .done_i(done),
    .act_o(act), .watch_low_o(watch_low), .step_o(step), .flush_o(flush),
    .mode_eff_o(mode_eff)
  );
endmodule

// File: rtl/tmp_alert_chk.sv
module tmp_alert_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_fire,
  input logic       rd_i,
  input logic       ara_i,
  input logic       sd_i,
  input logic       gc_i,
  input logic       mode_i,
  input logic       mode_eff,
  input logic       act,
  input logic [2:0] cnt
);
  logic mode_d, sd_d, act_d, evt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_d <= 1'b0; sd_d <= 1'b0; act_d <= 1'b0; evt_q <= 1'b1;
    end else begin
      mode_d <= mode_i; sd_d <= sd_i; act_d <= act;
      evt_q  <= smp_fire | rd_i | ara_i | gc_i | (sd_i & ~sd_d) | (mode_i != mode_d);
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 3'd5);
  assert_gc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n) gc_i |=> !act);
  assert_int_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff && act && (rd_i || ara_i) && !gc_i) |=> !act);
  assert_rise_needs_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(smp_fire));
  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_q |-> (act == act_d));
endmodule

bind tmp_alert_top tmp_alert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_fire(smp_fire), .rd_i(rd_i), .ara_i(ara_i),
  .sd_i(sd_i), .gc_i(gc_i), .mode_i(mode_i), .mode_eff(mode_eff), .act(act), .cnt(cnt)
);

// File: tb/sim_tmp_alert_top.sv
module sim_tmp_alert_top;
  localparam int TW = 12;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_ready;
  logic [TW-1:0] temp = '0, hi = 12'd1280, lo = 12'd1200;
  logic mode = 0, pol = 0, sd = 0, rd = 0, ara = 0, gc = 0, alert;
  logic [1:0] fq = 2'b00;
  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  tmp_alert_top #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid), .smp_ready_o(smp_ready),
    .smp_temp_i(temp), .lim_hi_i(hi), .lim_lo_i(lo), .mode_i(mode), .fq_sel_i(fq),
    .pol_i(pol), .sd_i(sd), .rd_i(rd), .ara_i(ara), .gc_i(gc), .alert_o(alert)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_alert(input string req, input bit active);
    chk(req, alert, pol ? active : ~active);
  endtask

  task automatic sample(input int t);
    temp = TW'(t); smp_valid = 1;
    @(posedge clk); @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic samples(input int t, input int k);
    for (int i = 0; i < k; i++) sample(t);
  endtask

  task automatic pulse_rd();  rd = 1;  @(posedge clk); @(negedge clk); rd = 0;  endtask
  task automatic pulse_ara(); ara = 1; @(posedge clk); @(negedge clk); ara = 0; endtask
  task automatic idle(input int k); for (int i = 0; i < k; i++) @(negedge clk); endtask

  task automatic t_reset();
    chk_alert("R9 reset inactive", 0);
    chk("R7 ready after reset", smp_ready, 1'b1);
  endtask

  task automatic t_comp_basic();
    fq = 2'b00; sample(1280); chk_alert("R1 N=1 assert at equal hi", 1);
    idle(3); chk_alert("R10 holds between samples", 1);
    sample(1199); chk_alert("R2 N=1 deassert", 0);
    fq = 2'b11; samples(1300, 5); chk_alert("R1 N=6 not after 5", 0);
    sample(1300); chk_alert("R1 N=6 after 6", 1);
    fq = 2'b01; sample(1199); sample(1200); sample(1199);
    chk_alert("R2 equal lo breaks run", 1);
    sample(1199); chk_alert("R2 N=2 deassert", 0);
    fq = 2'b10; samples(1280, 3); chk_alert("R1 N=4 not after 3", 0);
    sample(1280); chk_alert("R1 N=4 after 4", 1);
    samples(1199, 4); chk_alert("R2 N=4 deassert", 0);
  endtask

  task automatic t_fault_reset();
    fq = 2'b01; sample(1280); sample(1250); sample(1280);
    chk_alert("R3 break resets count", 0);
    sample(1280); chk_alert("R3 run completes", 1);
    pulse_rd(); chk_alert("R5 read ignored in comparator", 1);
    samples(1199, 2); chk_alert("R2 back to inactive", 0);
  endtask

  task automatic t_signed();
    fq = 2'b00; hi = 12'd1281; sample(1280); chk_alert("R8 hi LSB blocks", 0);
    hi = 12'd16; lo = 12'd8; sample(-16); chk_alert("R8 negative below positive hi", 0);
    hi = -12'sd2048; lo = -12'sd2048; sample(2047); chk_alert("R8 max above min", 1);
    hi = 12'd1280; lo = 12'd1200; sample(-2048); chk_alert("R8 min below lo", 0);
  endtask

  task automatic t_interrupt();
    fq = 2'b01; mode = 1; idle(1);
    sample(1280); chk_alert("R4 not after 1", 0);
    sample(1280); chk_alert("R4 after 2", 1);
    samples(1199, 3); chk_alert("R4 samples ignored while active", 1);
    pulse_rd(); chk_alert("R5 read clears", 0);
    samples(1280, 3); chk_alert("R6 high ignored when armed low", 0);
    samples(1199, 2); chk_alert("R6 low asserts", 1);
    pulse_ara(); chk_alert("R5 ack clears", 0);
    sample(1199); sample(1199); chk_alert("R6 low ignored when armed high", 0);
    samples(1280, 2); chk_alert("R6 high asserts again", 1);
    sd = 1; idle(1); chk_alert("R5 shutdown clears", 0);
    sd = 0;
  endtask

  task automatic t_gcall();
    samples(1199, 2); chk_alert("R6 armed low before gc", 1);
    gc = 1; smp_valid = 1; temp = 12'd1280; #1;
    chk("R7 ready low", smp_ready, 1'b0);
    @(posedge clk); @(negedge clk); gc = 0; smp_valid = 0;
    chk_alert("R7 gc clears", 0);
    samples(1280, 2); chk_alert("R7 comparator forced assert", 1);
    pulse_rd(); chk_alert("R7 read ignored when forced", 1);
    mode = 0; idle(1); mode = 1; idle(1);
    chk_alert("R10 mode change clears", 0);
    samples(1280, 2); chk_alert("R7 interrupt resumes", 1);
  endtask

  task automatic t_polarity();
    pol = 1; idle(1); chk("R9 active-high", alert, 1'b1);
    pol = 0; idle(1); chk("R9 active-low", alert, 1'b0);
  endtask

  initial begin
    idle(2); rst_n = 1; idle(1);
    t_reset(); t_comp_basic(); t_fault_reset(); t_signed();
    t_interrupt(); t_gcall(); t_polarity();
    done_flag = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done_flag; c++) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule